// File: doc/BRIEF.md
# GPIO Edge Interrupt Status Unit

This unit watches a bank of general-purpose input pins and turns their transitions into latched interrupt status. Each pin carries a polarity bit that decides which transition direction counts as an "assert" event; the opposite direction is recorded as a "deassert" event. The two kinds of event are kept in separate status banks. Each bank drives its own interrupt line, and a line is raised whenever any pin has a pending status bit whose enable bit is also set.

Inputs are first passed through a multi-flop synchronizer. Edges are found by comparing each synchronized level with the level from the previous cycle. A status bit latches on its event even when the pin is not enabled, so software can poll it. The bit stays set until a write-one-to-clear. The enable and polarity settings pack 32 pins per word. The status words pack 31 pins per word in bits 31..1, and bit 0 is always zero. A flat word-addressed port reaches every word. Address bits [5:4] select the region: 0 is enable, 1 is polarity, 2 is assert status and 3 is deassert status. Address bits [3:0] give the word index, and reads return data in the same cycle.

Top module: `gpio_edge_irq`

## Requirements
- R1: With polarity 1, a rising transition on a pin sets that pin's assert-status bit, and a falling transition sets its deassert-status bit.
- R2: With polarity 0, a falling transition sets the assert-status bit, and a rising transition sets the deassert-status bit.
- R3: In both status regions (address region 2 for assert, 3 for deassert), pin p sits in word p/31 at bit (p mod 31)+1. Bit 0 of every status word reads 0, and any bit that maps to no existing pin reads 0.
- R4: In the enable region (0) and the polarity region (1), pin p sits in word p/32 at bit p mod 32. Written values read back unchanged, and words beyond the pin count read 0.
- R5: Writing a status word clears exactly the bits written as 1. Bits written as 0, and bit 0, leave the status unchanged.
- R6: A status bit latches whether or not its pin is enabled. The assert interrupt output is the OR over all pins of (assert status AND enable), and the deassert output is the same for deassert status.
- R7: When an event and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R8: Rewriting a pin's polarity while its input level is steady creates no event in either bank.
- R9: Reset (synchronous, active high) clears all status, enable and polarity bits and drops both interrupt outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_PINS | Asynchronous GPIO input levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | IDX_W+2 | Region in the top two bits, word index below |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_assert_o | output | 1 | Pending enabled assert event |
| irq_deassert_o | output | 1 | Pending enabled deassert event |

## Verification
A transition's event and a write-one-to-clear can land on the same status bit in the same cycle. The bench sets a bit with a rising edge and then drives a second rising edge. It times the clearing write so that the write's clock edge is exactly the edge at which the synchronized level first differs from the previous sample. The status word is then read back and must still hold the bit. A clearing write issued one cycle later must remove it.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int WORD_W    = 32;
    localparam int CFG_PINS  = 32;
    localparam int STAT_PINS = 31;

    typedef enum logic [1:0] {
        REG_ENABLE   = 2'd0,
        REG_POLARITY = 2'd1,
        REG_STAT_AS  = 2'd2,
        REG_STAT_DE  = 2'd3
    } reg_region_e;

    typedef struct packed {
        logic asrt;
        logic deas;
    } pin_evt_t;

    function automatic int cfg_word(input int p);
        return p / CFG_PINS;
    endfunction

    function automatic int cfg_bit(input int p);
        return p % CFG_PINS;
    endfunction

    function automatic int stat_word(input int p);
        return p / STAT_PINS;
    endfunction

    function automatic int stat_bit(input int p);
        return (p % STAT_PINS) + 1;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 96,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 96
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] lvl_i,
    input  logic [NUM_PINS-1:0] pol_i,
    output logic [NUM_PINS-1:0] asrt_o,
    output logic [NUM_PINS-1:0] deas_o
);

    logic [NUM_PINS-1:0] prev_q;
    pin_evt_t [NUM_PINS-1:0] evt;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl_i;
    end

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            logic rise, fall;
            rise = lvl_i[p] & ~prev_q[p];
            fall = ~lvl_i[p] & prev_q[p];
            evt[p].asrt = pol_i[p] ? rise : fall;
            evt[p].deas = pol_i[p] ? fall : rise;
        end
    end

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            asrt_o[p] = evt[p].asrt;
            deas_o[p] = evt[p].deas;
        end
    end

    // R1 / R2 / R8: an event only where the synchronized level moved since the last cycle
    assert_evt_needs_change_R8: assert property (@(posedge clk) disable iff (rst)
        ((asrt_o | deas_o) & ~(lvl_i ^ $past(lvl_i))) == '0);

endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 96,
    parameter int IDX_W    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  logic [WORD_W-1:0]   wdata_i,
    output logic [NUM_PINS-1:0] bits_o,
    output logic [WORD_W-1:0]   rd_word_o
);

    logic [NUM_PINS-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else if (wr_i) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (idx_i == IDX_W'(cfg_word(p))) bits_q[p] <= wdata_i[cfg_bit(p)];
            end
        end
    end

    always_comb begin
        rd_word_o = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (idx_i == IDX_W'(cfg_word(p))) rd_word_o[cfg_bit(p)] = bits_q[p];
        end
    end

    assign bits_o = bits_q;

    // R4: without a write the settings hold
    assert_hold_without_write_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(bits_o));

endmodule

// File: rtl/gpio_status_bank.sv
module gpio_status_bank
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 96,
    parameter int IDX_W    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] evt_i,
    input  logic                wr_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  logic [WORD_W-1:0]   wdata_i,
    output logic [NUM_PINS-1:0] bits_o,
    output logic [WORD_W-1:0]   rd_word_o
);

    logic [NUM_PINS-1:0] bits_q;
    logic [NUM_PINS-1:0] clr;
    logic                unused_bit0;

    assign unused_bit0 = wdata_i[0];

    always_comb begin
        clr = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            clr[p] = wr_i && (idx_i == IDX_W'(stat_word(p))) && wdata_i[stat_bit(p)];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bits_q <= '0;
        else     bits_q <= (bits_q & ~clr) | evt_i;
    end

    always_comb begin
        rd_word_o = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (idx_i == IDX_W'(stat_word(p))) rd_word_o[stat_bit(p)] = bits_q[p];
        end
    end

    assign bits_o = bits_q;

    // R1 / R7: every event leaves its bit set, even under a clearing write
    assert_event_sets_R7: assert property (@(posedge clk) disable iff (rst)
        (evt_i != '0) |=> ((bits_o & $past(evt_i)) == $past(evt_i)));

    // R6: no bit appears without an event
    assert_no_spurious_set_R6: assert property (@(posedge clk) disable iff (rst)
        (bits_o & ~$past(bits_o) & ~$past(evt_i)) == '0);

    // R5: a written 1 without a competing event clears the bit
    assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> ((bits_o & $past(clr & ~evt_i)) == '0));

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS    = 96,
    parameter int SYNC_STAGES = 2,
    parameter int IDX_W       = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                reg_wr,
    input  logic [IDX_W+1:0]    reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    output logic                irq_assert_o,
    output logic                irq_deassert_o
);

    localparam int ADDR_W = IDX_W + 2;

    reg_region_e         region;
    logic [IDX_W-1:0]    idx;
    logic [NUM_PINS-1:0] lvl, asrt_evt, deas_evt;
    logic [NUM_PINS-1:0] en_bits, pol_bits, sa_bits, sd_bits;
    logic [WORD_W-1:0]   en_rd, pol_rd, sa_rd, sd_rd;
    logic                wr_en, wr_pol, wr_sa, wr_sd;

    assign region = reg_region_e'(reg_addr[ADDR_W-1 -: 2]);
    assign idx    = reg_addr[IDX_W-1:0];
    assign wr_en  = reg_wr && (region == REG_ENABLE);
    assign wr_pol = reg_wr && (region == REG_POLARITY);
    assign wr_sa  = reg_wr && (region == REG_STAT_AS);
    assign wr_sd  = reg_wr && (region == REG_STAT_DE);

    gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_i(pin_i), .q_o(lvl)
    );

    gpio_edge_detect #(.NUM_PINS(NUM_PINS)) u_edge (
        .clk(clk), .rst(rst), .lvl_i(lvl), .pol_i(pol_bits),
        .asrt_o(asrt_evt), .deas_o(deas_evt)
    );

    gpio_cfg_bank #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_enable (
        .clk(clk), .rst(rst), .wr_i(wr_en), .idx_i(idx), .wdata_i(reg_wdata),
        .bits_o(en_bits), .rd_word_o(en_rd)
    );

    gpio_cfg_bank #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_polarity (
        .clk(clk), .rst(rst), .wr_i(wr_pol), .idx_i(idx), .wdata_i(reg_wdata),
        .bits_o(pol_bits), .rd_word_o(pol_rd)
    );

    gpio_status_bank #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_stat_as (
        .clk(clk), .rst(rst), .evt_i(asrt_evt), .wr_i(wr_sa), .idx_i(idx),
        .wdata_i(reg_wdata), .bits_o(sa_bits), .rd_word_o(sa_rd)
    );

    gpio_status_bank #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_stat_de (
        .clk(clk), .rst(rst), .evt_i(deas_evt), .wr_i(wr_sd), .idx_i(idx),
        .wdata_i(reg_wdata), .bits_o(sd_bits), .rd_word_o(sd_rd)
    );

    always_comb begin
        unique case (region)
            REG_ENABLE:   reg_rdata = en_rd;
            REG_POLARITY: reg_rdata = pol_rd;
            REG_STAT_AS:  reg_rdata = sa_rd;
            REG_STAT_DE:  reg_rdata = sd_rd;
            default:      reg_rdata = '0;
        endcase
    end

    assign irq_assert_o   = |(sa_bits & en_bits);
    assign irq_deassert_o = |(sd_bits & en_bits);

    // R6: the assert line only rises after an assert event or an enable write
    assert_irq_as_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_assert_o) |-> $past((asrt_evt != '0) || wr_en));

    // R6: same for the deassert line
    assert_irq_de_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_deassert_o) |-> $past((deas_evt != '0) || wr_en));

    // R3: bit 0 of a status word never reads 1
    assert_stat_bit0_zero_R3: assert property (@(posedge clk) disable iff (rst)
        ((region == REG_STAT_AS) || (region == REG_STAT_DE)) |-> !reg_rdata[0]);

endmodule

// File: tb/gpio_edge_irq_tb.sv
module gpio_edge_irq_tb;

    localparam int N     = 96;
    localparam int IDX_W = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic [N-1:0]      pin_i;
    logic              reg_wr;
    logic [IDX_W+1:0]  reg_addr;
    logic [31:0]       reg_wdata;
    logic [31:0]       reg_rdata;
    logic              irq_assert_o, irq_deassert_o;

    int checks = 0;
    int errors = 0;

    logic [N-1:0] m_en, m_pol, m_sa, m_sd;

    always #4 clk = ~clk;

    gpio_edge_irq #(.NUM_PINS(N), .SYNC_STAGES(2), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst(rst), .pin_i(pin_i), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_assert_o(irq_assert_o), .irq_deassert_o(irq_deassert_o)
    );

    function automatic logic [31:0] model_word(input int region, input int idx);
        logic [31:0] w = '0;
        for (int b = 0; b < 32; b++) begin
            int pc = idx * 32 + b;
            int ps = idx * 31 + b - 1;
            case (region)
                0: if (pc < N) w[b] = m_en[pc];
                1: if (pc < N) w[b] = m_pol[pc];
                2: if (b > 0 && ps < N) w[b] = m_sa[ps];
                default: if (b > 0 && ps < N) w[b] = m_sd[ps];
            endcase
        end
        return w;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: %s got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input int region, input int idx, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = {2'(region), 4'(idx)}; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
        for (int p = 0; p < N; p++) begin
            if (region == 0 && p / 32 == idx) m_en[p] = data[p % 32];
            if (region == 1 && p / 32 == idx) m_pol[p] = data[p % 32];
            if (region == 2 && p / 31 == idx && data[p % 31 + 1]) m_sa[p] = 1'b0;
            if (region == 3 && p / 31 == idx && data[p % 31 + 1]) m_sd[p] = 1'b0;
        end
    endtask

    task automatic chk_word(input string req, input int region, input int idx);
        @(negedge clk);
        reg_addr = {2'(region), 4'(idx)};
        #1;
        chk(req, $sformatf("region %0d word %0d", region, idx), reg_rdata, model_word(region, idx));
    endtask

    task automatic chk_irq(input string req);
        @(negedge clk);
        chk(req, "irq_assert", {31'd0, irq_assert_o}, {31'd0, |(m_sa & m_en)});
        chk(req, "irq_deassert", {31'd0, irq_deassert_o}, {31'd0, |(m_sd & m_en)});
    endtask

    task automatic chk_all(input string req);
        for (int r = 0; r < 4; r++)
            for (int i = 0; i < 5; i++) chk_word(req, r, i);
    endtask

    task automatic toggle(input int p, input logic val);
        @(negedge clk);
        if (pin_i[p] != val) begin
            if (m_pol[p] == val) m_sa[p] = 1'b1;
            else                 m_sd[p] = 1'b1;
        end
        pin_i[p] = val;
        repeat (4) @(negedge clk);
    endtask

    task automatic sweep(input string req);
        for (int p = 0; p < N; p++) begin
            toggle(p, 1'b1);
            chk_word(req, 2, p / 31);
            chk_word(req, 3, p / 31);
            toggle(p, 1'b0);
            chk_word(req, 2, p / 31);
            chk_word(req, 3, p / 31);
            chk_irq("R6");
            do_write(2, p / 31, 32'h1 << (p % 31 + 1));
            do_write(3, p / 31, 32'h1 << (p % 31 + 1));
            chk_word("R5", 2, p / 31);
            chk_word("R5", 3, p / 31);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete got hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; pin_i = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        m_en = '0; m_pol = '0; m_sa = '0; m_sd = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk_all("R9");
        chk_irq("R9");

        // R4: config words read back; word 3 has no pins
        for (int i = 0; i < 4; i++) do_write(0, i, 32'hA5C3_0F01 ^ (i * 32'h1111_2222));
        for (int i = 0; i < 4; i++) chk_word("R4", 0, i);
        for (int i = 0; i < 4; i++) do_write(1, i, 32'h5A3C_F0E1 + i);
        for (int i = 0; i < 4; i++) chk_word("R4", 1, i);
        for (int i = 0; i < 3; i++) do_write(0, i, 32'h0);
        for (int i = 0; i < 3; i++) do_write(1, i, 32'hFFFF_FFFF);

        // R1 / R3: polarity 1 sweep over every pin
        sweep("R1");
        // R2 / R3: polarity 0 sweep over every pin
        for (int i = 0; i < 3; i++) do_write(1, i, 32'h0);
        sweep("R2");
        for (int i = 0; i < 3; i++) do_write(1, i, 32'hFFFF_FFFF);
        chk_word("R3", 2, 3);
        chk_word("R3", 3, 4);

        // R5: zeros and bit 0 do not clear, ones clear only their bit
        toggle(0, 1'b1); toggle(1, 1'b1); toggle(2, 1'b1);
        do_write(2, 0, 32'h0);
        chk_word("R5", 2, 0);
        do_write(2, 0, 32'h1);
        chk_word("R5", 2, 0);
        do_write(2, 0, 32'h4);
        chk_word("R5", 2, 0);
        toggle(0, 1'b0); toggle(1, 1'b0); toggle(2, 1'b0);
        do_write(2, 0, 32'hFFFF_FFFF); do_write(3, 0, 32'hFFFF_FFFF);
        chk_word("R5", 2, 0);
        chk_word("R5", 3, 0);

        // R6: interrupt lines follow status AND enable
        do_write(0, 1, 32'h100);        // pin 40
        chk_irq("R6");
        toggle(40, 1'b1);
        chk_irq("R6");
        toggle(40, 1'b0);
        chk_irq("R6");
        toggle(41, 1'b1);               // not enabled: status only
        chk_word("R6", 2, 1);
        do_write(0, 1, 32'h0);
        chk_irq("R6");
        chk_word("R6", 2, 1);
        chk_word("R6", 3, 1);
        toggle(41, 1'b0);
        do_write(2, 1, 32'hFFFF_FFFF); do_write(3, 1, 32'hFFFF_FFFF);

        // R7: event and clearing write in the same cycle
        toggle(10, 1'b1);
        toggle(10, 1'b0);
        @(negedge clk);
        pin_i[10] = 1'b1;               // synchronized level differs from previous two edges later
        @(negedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = {2'd2, 4'd0}; reg_wdata = 32'h1 << 11;
        @(negedge clk);
        reg_wr = 1'b0;
        m_sa[10] = 1'b1;
        repeat (3) @(negedge clk);
        chk_word("R7", 2, 0);
        do_write(2, 0, 32'h1 << 11);
        chk_word("R7", 2, 0);

        // R8: polarity flips on a steady high pin create nothing
        do_write(3, 0, 32'hFFFF_FFFF);
        do_write(1, 0, 32'h0);
        repeat (4) @(negedge clk);
        chk_word("R8", 2, 0);
        chk_word("R8", 3, 0);
        do_write(1, 0, 32'hFFFF_FFFF);
        repeat (4) @(negedge clk);
        chk_word("R8", 2, 0);
        chk_word("R8", 3, 0);
        toggle(10, 1'b0);
        chk_word("R8", 3, 0);
        do_write(3, 0, 32'hFFFF_FFFF);

        // R9: reset in mid-run clears everything
        do_write(0, 2, 32'hFFFF_FFFF);
        toggle(70, 1'b1);
        toggle(70, 1'b0);
        chk_irq("R9");
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        m_en = '0; m_pol = '0; m_sa = '0; m_sd = '0;
        chk_all("R9");
        chk_irq("R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule